// File: doc/BRIEF.md
# Deep-Sleep Transition Ordering Monitor

This block is a passive observer placed beside a power sequencer. Each cycle it sees one strobe for every accepted transition type: power-up, deep-sleep entry, deep-sleep exit and power-down. It checks two ordering rules. First, once a deep-sleep entry has been accepted, the next accepted transition must be a deep-sleep exit. Second, a deep-sleep exit must never be accepted unless an entry is outstanding. It never drives or blocks the sequencer.

The block keeps one internal bit that records "the last accepted transition was an entry". Idle cycles leave that bit alone, so any amount of idle time between an entry and its exit is allowed. A cycle that carries more than one strobe is a violation of its own kind and does not change the bit. Every violation raises a pulse and sets a sticky flag that only reset clears. A small code reports the cause of the first violation. One parameter decides whether the pulse is registered, so it appears one cycle after the offending strobes, or combinational, so it appears in the same cycle.

Top module: `seq_order_monitor`

## Requirements
- R1: While reset is asserted, and just after it is released, `viol_pulse_o` and `viol_sticky_o` are 0, `viol_code_o` is 0 and no entry is outstanding.
- R2: A cycle with only `sleep_exit_i` high, while an entry is outstanding, is not a violation and leaves no entry outstanding.
- R3: While an entry is outstanding, a cycle with exactly one strobe, that strobe being power-up, power-down or entry, is a violation with cause code 1. A lone entry still marks an entry as outstanding afterwards.
- R4: A cycle with only `sleep_exit_i` high, while no entry is outstanding, is a violation with cause code 2.
- R5: A cycle with no strobe is never a violation and does not change whether an entry is outstanding.
- R6: A cycle with two or more strobes high is a violation with cause code 3 and does not change whether an entry is outstanding.
- R7: With the default `PULSE_REG`=1, `viol_pulse_o` is high in exactly the cycle after each cycle that holds a violation and low otherwise. With `PULSE_REG`=0 it is high in the same cycle.
- R8: `viol_sticky_o` rises with the first violation and stays high until reset. From then on `viol_code_o` holds the cause code of that first violation, and it is 0 before any violation.
- R9: A lone power-up or power-down strobe while no entry is outstanding is not a violation, and a lone power-up or power-down always leaves no entry outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Accepted power-up transition strobe |
| sleep_enter_i | input | 1 | Accepted deep-sleep entry strobe |
| sleep_exit_i | input | 1 | Accepted deep-sleep exit strobe |
| pwr_down_i | input | 1 | Accepted power-down transition strobe |
| viol_pulse_o | output | 1 | Violation pulse, one cycle per violating cycle |
| viol_sticky_o | output | 1 | Violation seen since reset |
| viol_code_o | output | CODE_W | Cause of the first violation (0 none, 1 wrong follower, 2 exit without entry, 3 simultaneous strobes) |

## Verification
The bench builds the monitor with its default parameters: a registered pulse and a 2-bit code. With these the one-cycle pulse latency, the capture of the first cause code and the hold-until-reset behaviour can all be observed at the ports. The random stimulus mixes idle cycles, single strobes and multi-strobe cycles, and it resets the block at random times. This exercises the outstanding-entry bit across long idle gaps, back-to-back violations and every cause code after a fresh reset.

// File: rtl/seq_order_pkg.sv
package seq_order_pkg;

   localparam int unsigned N_EVT     = 4;
   localparam int unsigned EV_UP     = 0;
   localparam int unsigned EV_ENTER  = 1;
   localparam int unsigned EV_EXIT   = 2;
   localparam int unsigned EV_DOWN   = 3;
   localparam int unsigned CAUSE_W   = 2;

   typedef enum logic [CAUSE_W-1:0] {
      VC_NONE        = 2'd0,
      VC_BAD_FOLLOW  = 2'd1,
      VC_ORPHAN_EXIT = 2'd2,
      VC_MULTI       = 2'd3
   } viol_cause_e;

   // Classification of one cycle's strobes
   typedef struct packed {
      logic multi;   // two or more strobes
      logic enter;   // entry strobe alone
      logic exit_s;  // exit strobe alone
      logic other;   // any other strobe alone
   } strobe_class_t;

endpackage

// File: rtl/sqm_strobe_classify.sv
module sqm_strobe_classify
   import seq_order_pkg::*;
#(
   parameter int unsigned N         = 4,
   parameter int unsigned ENTER_IDX = 1,
   parameter int unsigned EXIT_IDX  = 2
) (
   input  logic [N-1:0]  strobe_i,
   output strobe_class_t cls_o
);

   localparam int unsigned CNT_W = $clog2(N + 1);

   generate
      if (ENTER_IDX >= N || EXIT_IDX >= N || ENTER_IDX == EXIT_IDX) begin : g_bad_idx
         $error("sqm_strobe_classify: entry/exit index out of range or equal");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic             single;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < int'(N); i++) begin
         cnt = cnt + CNT_W'(strobe_i[i]);
      end
   end

   assign single       = (cnt == CNT_W'(1));
   assign cls_o.multi  = (cnt > CNT_W'(1));
   assign cls_o.enter  = single & strobe_i[ENTER_IDX];
   assign cls_o.exit_s = single & strobe_i[EXIT_IDX];
   assign cls_o.other  = single & ~strobe_i[ENTER_IDX] & ~strobe_i[EXIT_IDX];

endmodule

// File: rtl/sqm_entry_tracker.sv
module sqm_entry_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
      end else if (set_i) begin
         pend_o <= 1'b1;
      end else if (clr_i) begin
         pend_o <= 1'b0;
      end
   end

endmodule

// File: rtl/sqm_viol_report.sv
module sqm_viol_report
   import seq_order_pkg::*;
#(
   parameter bit          PULSE_REG = 1'b1,
   parameter int unsigned CODE_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  strobe_class_t     cls_i,
   input  logic              pend_i,
   output logic              pulse_o,
   output logic              sticky_o,
   output logic [CODE_W-1:0] code_o
);

   viol_cause_e cause_now;
   viol_cause_e cause_q;
   logic        hit;
   logic        sticky_q;

   always_comb begin
      if (cls_i.multi) begin
         cause_now = VC_MULTI;
      end else if (pend_i && (cls_i.enter || cls_i.other)) begin
         cause_now = VC_BAD_FOLLOW;
      end else if (!pend_i && cls_i.exit_s) begin
         cause_now = VC_ORPHAN_EXIT;
      end else begin
         cause_now = VC_NONE;
      end
   end

   assign hit = (cause_now != VC_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
         cause_q  <= VC_NONE;
      end else if (hit && !sticky_q) begin
         sticky_q <= 1'b1;
         cause_q  <= cause_now;
      end
   end

   generate
      if (PULSE_REG) begin : g_reg_pulse
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= hit;
            end
         end
         assign pulse_o  = pulse_q;
         assign sticky_o = sticky_q;
         assign code_o   = CODE_W'(cause_q);
      end else begin : g_comb_pulse
         logic live;
         assign live     = rst_n & hit;
         assign pulse_o  = live;
         assign sticky_o = sticky_q | live;
         assign code_o   = sticky_q ? CODE_W'(cause_q)
                         : (live ? CODE_W'(cause_now) : '0);
      end
   endgenerate

endmodule

// File: rtl/seq_order_monitor.sv
module seq_order_monitor
   import seq_order_pkg::*;
#(
   parameter bit          PULSE_REG = 1'b1,
   parameter int unsigned CODE_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up_i,
   input  logic              sleep_enter_i,
   input  logic              sleep_exit_i,
   input  logic              pwr_down_i,
   output logic              viol_pulse_o,
   output logic              viol_sticky_o,
   output logic [CODE_W-1:0] viol_code_o
);

   generate
      if (CODE_W < CAUSE_W) begin : g_bad_code_w
         $error("seq_order_monitor: CODE_W too narrow for cause codes");
      end
   endgenerate

   logic [N_EVT-1:0] strobes;
   strobe_class_t    cls;
   logic             pend;

   always_comb begin
      strobes           = '0;
      strobes[EV_UP]    = pwr_up_i;
      strobes[EV_ENTER] = sleep_enter_i;
      strobes[EV_EXIT]  = sleep_exit_i;
      strobes[EV_DOWN]  = pwr_down_i;
   end

   sqm_strobe_classify #(
      .N         (N_EVT),
      .ENTER_IDX (EV_ENTER),
      .EXIT_IDX  (EV_EXIT)
   ) u_classify (
      .strobe_i (strobes),
      .cls_o    (cls)
   );

   sqm_entry_tracker u_tracker (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (cls.enter),
      .clr_i  (cls.exit_s | cls.other),
      .pend_o (pend)
   );

   sqm_viol_report #(
      .PULSE_REG (PULSE_REG),
      .CODE_W    (CODE_W)
   ) u_report (
      .clk      (clk),
      .rst_n    (rst_n),
      .cls_i    (cls),
      .pend_i   (pend),
      .pulse_o  (viol_pulse_o),
      .sticky_o (viol_sticky_o),
      .code_o   (viol_code_o)
   );

endmodule

// File: rtl/seq_order_monitor_chk.sv
module seq_order_monitor_chk #(
   parameter bit          PULSE_REG = 1'b1,
   parameter int unsigned CODE_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pwr_up_i,
   input logic              sleep_enter_i,
   input logic              sleep_exit_i,
   input logic              pwr_down_i,
   input logic              viol_pulse_o,
   input logic              viol_sticky_o,
   input logic [CODE_W-1:0] viol_code_o
);

   logic [3:0] s;
   logic       only_enter;
   logic       only_exit;
   logic       idle;

   assign s          = {pwr_down_i, sleep_exit_i, sleep_enter_i, pwr_up_i};
   assign only_enter = (s == 4'b0010);
   assign only_exit  = (s == 4'b0100);
   assign idle       = (s == 4'b0000);

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_CLEAR: assert (!viol_pulse_o && !viol_sticky_o && viol_code_o == '0); // R1
      end
   end

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky_o |=> viol_sticky_o); // R8

   AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky_o |=> $stable(viol_code_o)); // R8

   AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      viol_sticky_o |-> (viol_code_o != '0)); // R8

   generate
      if (PULSE_REG) begin : g_reg
         AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(s) > 1) |=> viol_pulse_o); // R6
         AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            idle |=> !viol_pulse_o); // R5
         AST_PAIR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            only_enter ##1 only_exit |=> !viol_pulse_o); // R2
         AST_DOUBLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            only_exit ##1 only_exit |=> viol_pulse_o); // R4
      end else begin : g_comb
         AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(s) > 1) |-> viol_pulse_o); // R6
         AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            idle |-> !viol_pulse_o); // R5
         AST_PAIR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
            only_enter ##1 only_exit |-> !viol_pulse_o); // R2
         AST_DOUBLE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            only_exit ##1 only_exit |-> viol_pulse_o); // R4
      end
   endgenerate

endmodule

bind seq_order_monitor seq_order_monitor_chk #(
   .PULSE_REG (PULSE_REG),
   .CODE_W    (CODE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .pwr_up_i      (pwr_up_i),
   .sleep_enter_i (sleep_enter_i),
   .sleep_exit_i  (sleep_exit_i),
   .pwr_down_i    (pwr_down_i),
   .viol_pulse_o  (viol_pulse_o),
   .viol_sticky_o (viol_sticky_o),
   .viol_code_o   (viol_code_o)
);

// File: tb/seq_order_monitor_tb.sv
module seq_order_monitor_tb;

   localparam logic [3:0] S_NONE  = 4'b0000;
   localparam logic [3:0] S_UP    = 4'b0001;
   localparam logic [3:0] S_ENTER = 4'b0010;
   localparam logic [3:0] S_EXIT  = 4'b0100;
   localparam logic [3:0] S_DOWN  = 4'b1000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       up, enter, ex, down;
   logic       pulse, sticky;
   logic [1:0] code;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic       m_pend, m_sticky, m_pulse;
   logic [1:0] m_code;

   always #10 clk = ~clk;

   seq_order_monitor u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pwr_up_i      (up),
      .sleep_enter_i (enter),
      .sleep_exit_i  (ex),
      .pwr_down_i    (down),
      .viol_pulse_o  (pulse),
      .viol_sticky_o (sticky),
      .viol_code_o   (code)
   );

   function automatic logic [1:0] exp_cause(input logic [3:0] st, input logic pend);
      int ones = 0;
      for (int i = 0; i < 4; i++) ones += int'(st[i]);
      if (ones > 1) return 2'd3;                                  // R6
      if (ones == 1 && pend && st != S_EXIT) return 2'd1;         // R3
      if (st == S_EXIT && !pend) return 2'd2;                     // R4
      return 2'd0;
   endfunction

   function automatic logic next_pend(input logic [3:0] st, input logic pend);
      int ones = 0;
      for (int i = 0; i < 4; i++) ones += int'(st[i]);
      if (ones != 1) return pend;       // R5, R6
      return (st == S_ENTER);           // R2, R3, R9
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {down, ex, enter, up} = S_NONE;
      @(negedge clk);
      check("R1", "pulse in reset", {1'b0, pulse}, 2'd0);
      check("R1", "sticky in reset", {1'b0, sticky}, 2'd0);
      check("R1", "code in reset", code, 2'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_pend = 1'b0; m_sticky = 1'b0; m_code = 2'd0; m_pulse = 1'b0;
   endtask

   task automatic step(input logic [3:0] st, input string tag_in);
      logic [1:0] c;
      string      tag;
      {down, ex, enter, up} = st;
      @(negedge clk);
      c = exp_cause(st, m_pend);
      m_pulse = (c != 2'd0);
      if (m_pulse && !m_sticky) begin
         m_sticky = 1'b1;
         m_code   = c;
      end
      m_pend = next_pend(st, m_pend);
      if (tag_in != "") tag = tag_in;
      else begin
         case (c)
            2'd1: tag = "R3";
            2'd2: tag = "R4";
            2'd3: tag = "R6";
            default: tag = (st == S_NONE) ? "R5" : "R2";
         endcase
      end
      check(tag, "pulse (R7)", {1'b0, pulse}, {1'b0, m_pulse});
      check(tag, "sticky (R8)", {1'b0, sticky}, {1'b0, m_sticky});
      check(tag, "code (R8)", code, m_code);
      {down, ex, enter, up} = S_NONE;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240131));
      do_reset();
      // R1: state just after release
      check("R1", "pulse after release", {1'b0, pulse}, 2'd0);
      check("R1", "code after release", code, 2'd0);

      // R2: clean pair
      step(S_ENTER, "R2");
      step(S_EXIT, "R2");
      // R5: idle after exit keeps flag clear, then an orphan exit
      repeat (3) step(S_NONE, "R5");
      step(S_EXIT, "R4");
      // R8: later violations leave the first code
      step(S_UP, "R9");
      step(S_ENTER, "R8");
      step(S_DOWN, "R8");
      step(S_NONE, "R7");

      // R5: long idle between entry and exit
      do_reset();
      step(S_ENTER, "R5");
      repeat (5) step(S_NONE, "R5");
      step(S_EXIT, "R5");
      step(S_DOWN, "R9");
      step(S_UP, "R9");

      // R3: entry followed by entry re-arms; R7 pulse per cycle
      do_reset();
      step(S_ENTER, "R3");
      step(S_ENTER, "R3");
      step(S_UP, "R7");
      step(S_EXIT, "R7");
      step(S_NONE, "R7");

      // R6: multi strobe leaves flag set
      do_reset();
      step(S_ENTER, "R6");
      step(S_ENTER | S_EXIT, "R6");
      step(S_EXIT, "R6");
      // R6: multi strobe leaves flag clear
      do_reset();
      step(S_ENTER | S_UP, "R6");
      step(S_EXIT, "R6");

      // R9: power-up after entry clears the flag
      do_reset();
      step(S_ENTER, "R9");
      step(S_UP, "R9");
      step(S_EXIT, "R9");

      // Random mix
      do_reset();
      for (int k = 0; k < 4000; k++) begin
         int r;
         logic [3:0] st;
         if (($urandom % 200) == 0) do_reset();
         r = $urandom % 16;
         if (r < 5) st = S_NONE;
         else if (r < 13) st = 4'b0001 << ($urandom % 4);
         else st = 4'($urandom % 16);
         step(st, "");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule